// File: doc/BRIEF.md
# Legacy Prefix Scanner for 16-bit x86 Instructions

This block sits at the front of an instruction decoder running in 16-bit mode. It takes the instruction byte stream one byte per accepted transfer and removes the legacy prefix bytes. Each prefix updates the state of its group. The first byte that is not a prefix ends the scan, and that byte is handed on as the opcode. One cycle later a single-cycle strobe presents the result: the opcode, the effective segment override, operand and address size, lock, repeat mode, the number of prefix bytes consumed, and a mask of the consumed bytes that a later prefix of the same group overrode.

Repeated prefixes from one group never stall or reject the instruction. The latest prefix of each group is the one that takes effect. Every earlier prefix it replaces is only marked in the dropped mask. The prefix run is capped at a parameterised length. If a prefix byte arrives once the cap is reached, that byte ends the instruction with an error flag set, instead of being consumed as a prefix.

Top module: `pfx_scan`

## Requirements
- R1: While reset is held, `res_valid` and `in_ready` are low. After reset is released, `in_ready` goes high and stays high.
- R2: Each accepted prefix byte is consumed. The first accepted non-prefix byte appears on `res_opcode`, and `res_count` equals the number of prefix bytes consumed before it.
- R3: `res_valid` is high for exactly one cycle, in the cycle after the byte that ends the instruction is accepted. Prefix bytes that are consumed raise no strobe.
- R4: Byte 0x66 sets `res_opsz32` and byte 0x67 sets `res_adsz32`. Both are 0 when their prefix is absent, which means the 16-bit default.
- R5: Segment override bytes map onto `res_seg` as follows: 0x26→1, 0x2E→2, 0x36→3, 0x3E→4, 0x64→5, 0x65→6. The value is 0 when no override is present. The last override in the stream wins.
- R6: Byte 0xF0 sets `res_lock`. Bytes 0xF2 and 0xF3 form one group that drives `res_rep` to 1 for 0xF2 and 2 for 0xF3, or 0 when neither is present. The last repeat byte wins.
- R7: Bit k of `res_drop` is 1 exactly when prefix byte k (counting from 0 at the first byte of the instruction) was followed later by a prefix of the same group. The groups are: segment, operand size, address size, lock, repeat. Bits at k ≥ `res_count` are 0.
- R8: Every group starts each instruction in its none/default state. Nothing carries over from the previous instruction.
- R9: With MAX_PFX (default 14) prefixes followed by an opcode, the result is normal and `res_error` is 0. If another prefix arrives after MAX_PFX prefixes, it is accepted and discarded. The strobe then shows `res_error`=1, `res_count`=MAX_PFX, and the fields of the first MAX_PFX prefixes, with the offending byte on `res_opcode`. The next byte starts a new instruction.
- R10: Cycles with `in_valid` low do not change the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| res_valid | output | 1 | One-cycle result strobe |
| res_opcode | output | 8 | Byte that ended the instruction |
| res_seg | output | 3 | Segment override code (0 none, 1..6) |
| res_opsz32 | output | 1 | 32-bit operand size selected |
| res_adsz32 | output | 1 | 32-bit address size selected |
| res_lock | output | 1 | Lock prefix present |
| res_rep | output | 2 | Repeat mode (0 none, 1 not-zero, 2 zero) |
| res_count | output | $clog2(MAX_PFX+1) | Prefix bytes consumed |
| res_drop | output | MAX_PFX | Superseded prefix byte mask |
| res_error | output | 1 | Prefix cap exceeded |

## Verification
If a group's last-position register is stale, the next repeat of that group marks the wrong bit in `res_drop`. That error is visible on the same strobe that carries the instruction. If group state is not cleared between instructions, the stale value shows on the next instruction's strobe, even when that instruction has no prefixes. The bench therefore runs a prefix-free instruction right after prefixed ones. A fault in the counter or the cap shows up as a wrong `res_count` or `res_error`, or as a missing or early strobe, at the fifteenth consecutive prefix.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    typedef enum logic [2:0] {
        SEG_NONE = 3'd0, SEG_ES = 3'd1, SEG_CS = 3'd2, SEG_SS = 3'd3,
        SEG_DS = 3'd4, SEG_FS = 3'd5, SEG_GS = 3'd6
    } seg_e;

    typedef enum logic [1:0] {
        REP_NONE = 2'd0, REP_NZ = 2'd1, REP_Z = 2'd2
    } rep_e;

    localparam int NGRP     = 5;
    localparam int GRP_SEG  = 0;
    localparam int GRP_OPSZ = 1;
    localparam int GRP_ADSZ = 2;
    localparam int GRP_LOCK = 3;
    localparam int GRP_REP  = 4;

    typedef struct packed {
        logic            is_pfx;
        logic [NGRP-1:0] grp_hit;
        seg_e            seg;
        rep_e            rep;
    } cls_t;
endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
    import pfx_pkg::*;
(
    input  logic [7:0] byte_i,
    output cls_t       cls_o
);
    always_comb begin
        cls_o = '0;
        case (byte_i)
            8'h26: begin cls_o.grp_hit[GRP_SEG] = 1'b1; cls_o.seg = SEG_ES; end
            8'h2E: begin cls_o.grp_hit[GRP_SEG] = 1'b1; cls_o.seg = SEG_CS; end
            8'h36: begin cls_o.grp_hit[GRP_SEG] = 1'b1; cls_o.seg = SEG_SS; end
            8'h3E: begin cls_o.grp_hit[GRP_SEG] = 1'b1; cls_o.seg = SEG_DS; end
            8'h64: begin cls_o.grp_hit[GRP_SEG] = 1'b1; cls_o.seg = SEG_FS; end
            8'h65: begin cls_o.grp_hit[GRP_SEG] = 1'b1; cls_o.seg = SEG_GS; end
            8'h66: cls_o.grp_hit[GRP_OPSZ] = 1'b1;
            8'h67: cls_o.grp_hit[GRP_ADSZ] = 1'b1;
            8'hF0: cls_o.grp_hit[GRP_LOCK] = 1'b1;
            8'hF2: begin cls_o.grp_hit[GRP_REP] = 1'b1; cls_o.rep = REP_NZ; end
            8'hF3: begin cls_o.grp_hit[GRP_REP] = 1'b1; cls_o.rep = REP_Z; end
            default: cls_o.grp_hit = '0;
        endcase
        cls_o.is_pfx = |cls_o.grp_hit;
    end
endmodule

// File: rtl/pfx_group_slot.sv
module pfx_group_slot #(
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             hit_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             kill_o,
    output logic [POS_W-1:0] kill_pos_o
);
    typedef struct packed {
        logic             seen;
        logic [POS_W-1:0] pos;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d     = slot_q;
        kill_o     = hit_i && slot_q.seen;
        kill_pos_o = slot_q.pos;
        if (clear_i) begin
            slot_d = '0;
        end else if (hit_i) begin
            slot_d.seen = 1'b1;
            slot_d.pos  = pos_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end
endmodule

// File: rtl/pfx_scan.sv
module pfx_scan
    import pfx_pkg::*;
#(
    parameter int MAX_PFX = 14,
    localparam int CNT_W  = $clog2(MAX_PFX + 1),
    localparam int POS_W  = (MAX_PFX > 1) ? $clog2(MAX_PFX) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [7:0]         in_byte,
    output logic               in_ready,
    output logic               res_valid,
    output logic [7:0]         res_opcode,
    output logic [2:0]         res_seg,
    output logic               res_opsz32,
    output logic               res_adsz32,
    output logic               res_lock,
    output logic [1:0]         res_rep,
    output logic [CNT_W-1:0]   res_count,
    output logic [MAX_PFX-1:0] res_drop,
    output logic               res_error
);
    typedef struct packed {
        seg_e               seg;
        logic               opsz;
        logic               adsz;
        logic               lock;
        rep_e               rep;
        logic [CNT_W-1:0]   cnt;
        logic [MAX_PFX-1:0] drop;
    } scan_t;

    typedef struct packed {
        logic               valid;
        logic [7:0]         opcode;
        seg_e               seg;
        logic               opsz;
        logic               adsz;
        logic               lock;
        rep_e               rep;
        logic [CNT_W-1:0]   cnt;
        logic [MAX_PFX-1:0] drop;
        logic               err;
    } res_t;

    scan_t scan_d, scan_q;
    res_t  res_d, res_q;
    logic  ready_d, ready_q;

    cls_t             cls;
    logic             take, full, accept_pfx, finish;
    logic [NGRP-1:0]  hits;
    logic [NGRP-1:0]  kill;
    logic [POS_W-1:0] kill_pos [NGRP];
    logic [POS_W-1:0] pos;
    logic [MAX_PFX-1:0] drop_new;

    pfx_classify u_cls (
        .byte_i (in_byte),
        .cls_o  (cls)
    );

    assign take       = in_valid && ready_q;
    assign full       = (scan_q.cnt == CNT_W'(MAX_PFX));
    assign accept_pfx = take && cls.is_pfx && !full;
    assign finish     = take && (!cls.is_pfx || full);
    assign hits       = accept_pfx ? cls.grp_hit : '0;
    assign pos        = POS_W'(scan_q.cnt);

    for (genvar g = 0; g < NGRP; g++) begin : g_slot
        pfx_group_slot #(.POS_W(POS_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear_i    (finish),
            .hit_i      (hits[g]),
            .pos_i      (pos),
            .kill_o     (kill[g]),
            .kill_pos_o (kill_pos[g])
        );
    end

    always_comb begin
        drop_new = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (kill[g]) drop_new[kill_pos[g]] = 1'b1;
        end
    end

    always_comb begin
        scan_d    = scan_q;
        res_d     = res_q;
        res_d.valid = 1'b0;
        ready_d   = 1'b1;

        if (accept_pfx) begin
            if (cls.grp_hit[GRP_SEG])  scan_d.seg  = cls.seg;
            if (cls.grp_hit[GRP_OPSZ]) scan_d.opsz = 1'b1;
            if (cls.grp_hit[GRP_ADSZ]) scan_d.adsz = 1'b1;
            if (cls.grp_hit[GRP_LOCK]) scan_d.lock = 1'b1;
            if (cls.grp_hit[GRP_REP])  scan_d.rep  = cls.rep;
            scan_d.cnt  = scan_q.cnt + CNT_W'(1);
            scan_d.drop = scan_q.drop | drop_new;
        end

        if (finish) begin
            res_d.valid  = 1'b1;
            res_d.opcode = in_byte;
            res_d.seg    = scan_q.seg;
            res_d.opsz   = scan_q.opsz;
            res_d.adsz   = scan_q.adsz;
            res_d.lock   = scan_q.lock;
            res_d.rep    = scan_q.rep;
            res_d.cnt    = scan_q.cnt;
            res_d.drop   = scan_q.drop;
            res_d.err    = cls.is_pfx;
            scan_d       = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_q  <= '0;
            res_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            scan_q  <= scan_d;
            res_q   <= res_d;
            ready_q <= ready_d;
        end
    end

    assign in_ready   = ready_q;
    assign res_valid  = res_q.valid;
    assign res_opcode = res_q.opcode;
    assign res_seg    = res_q.seg;
    assign res_opsz32 = res_q.opsz;
    assign res_adsz32 = res_q.adsz;
    assign res_lock   = res_q.lock;
    assign res_rep    = res_q.rep;
    assign res_count  = res_q.cnt;
    assign res_drop   = res_q.drop;
    assign res_error  = res_q.err;
endmodule

// File: rtl/pfx_scan_chk.sv
module pfx_scan_chk #(
    parameter int MAX_PFX = 14,
    localparam int CNT_W  = $clog2(MAX_PFX + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [7:0]         in_byte,
    input logic               in_ready,
    input logic               res_valid,
    input logic [7:0]         res_opcode,
    input logic [2:0]         res_seg,
    input logic               res_opsz32,
    input logic               res_adsz32,
    input logic               res_lock,
    input logic [1:0]         res_rep,
    input logic [CNT_W-1:0]   res_count,
    input logic [MAX_PFX-1:0] res_drop,
    input logic               res_error
);
    // R3
    strobe_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid && in_ready));

    // R9
    count_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_count <= CNT_W'(MAX_PFX)));

    // R9
    error_at_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_error) |-> (res_count == CNT_W'(MAX_PFX)));

    // R7
    drop_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_drop >> res_count) == '0));

    // R8
    bare_opcode_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_count == '0) |->
        (res_seg == 3'd0 && !res_opsz32 && !res_adsz32 && !res_lock && res_rep == 2'd0));
endmodule

bind pfx_scan pfx_scan_chk #(.MAX_PFX(MAX_PFX)) u_chk (.*);

// File: tb/tb_pfx_scan.sv
module tb_pfx_scan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready, res_valid, res_opsz32, res_adsz32, res_lock, res_error;
    logic [7:0]  res_opcode;
    logic [2:0]  res_seg;
    logic [1:0]  res_rep;
    logic [3:0]  res_count;
    logic [13:0] res_drop;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    logic [7:0] seq [16];

    always #5 clk = ~clk;

    pfx_scan dut (.*);

    always @(negedge clk) if (res_valid) strobes++;

    typedef struct packed {
        logic [3:0]  n;
        logic [47:0] b;
        logic [7:0]  op;
        logic [2:0]  seg;
        logic        opsz;
        logic        adsz;
        logic        lock;
        logic [1:0]  rep;
        logic [3:0]  cnt;
        logic [13:0] drop;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{4'd5, 48'h0040_6767_6666, 8'h40, 3'd0, 1'b1, 1'b1, 1'b0, 2'd0, 4'd4, 14'h0005},
        '{4'd1, 48'h0000_0000_0090, 8'h90, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0, 14'h0000},
        '{4'd4, 48'h0000_8B26_3E2E, 8'h8B, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0, 4'd3, 14'h0003},
        '{4'd3, 48'h0000_00A4_F2F3, 8'hA4, 3'd0, 1'b0, 1'b0, 1'b0, 2'd1, 4'd2, 14'h0001},
        '{4'd6, 48'h0167_65F0_64F0, 8'h01, 3'd6, 1'b0, 1'b1, 1'b1, 2'd0, 4'd5, 14'h0003},
        '{4'd4, 48'h0000_ADF3_6636, 8'hAD, 3'd3, 1'b1, 1'b0, 1'b0, 2'd2, 4'd3, 14'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // drive seq[0..n-1], then check the strobe and all result fields
    task automatic run_seq(input int n, input bit gaps, input vec_t e, input logic err);
        int s0;
        s0 = strobes;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = seq[i];
            if (gaps && i < n - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_byte  = 8'hF3;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk("R3 strobe count", 32'(strobes - s0), 32'd1);
        chk("R2 opcode", 32'(res_opcode), 32'(e.op));
        chk("R2 count", 32'(res_count), 32'(e.cnt));
        chk("R5 seg", 32'(res_seg), 32'(e.seg));
        chk("R4 opsz", 32'(res_opsz32), 32'(e.opsz));
        chk("R4 adsz", 32'(res_adsz32), 32'(e.adsz));
        chk("R6 lock", 32'(res_lock), 32'(e.lock));
        chk("R6 rep", 32'(res_rep), 32'(e.rep));
        chk("R7 drop", 32'(res_drop), 32'(e.drop));
        chk("R9 error", 32'(res_error), 32'(err));
        @(negedge clk);
        #1;
        chk("R3 one-cycle strobe", 32'(res_valid), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        vec_t e;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(res_valid), 32'd0);
        chk("R1 ready in reset", 32'(in_ready), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 ready after reset", 32'(in_ready), 32'd1);

        // table walk: R2 R4 R5 R6 R7, and R8 via the bare opcode after prefixes
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 6; i++) seq[i] = TBL[k].b[8*i +: 8];
            run_seq(int'(TBL[k].n), 1'b0, TBL[k], 1'b0);
        end

        // R10: idle cycles between bytes change nothing
        for (int i = 0; i < 6; i++) seq[i] = TBL[4].b[8*i +: 8];
        run_seq(int'(TBL[4].n), 1'b1, TBL[4], 1'b0);

        // R9: exactly the cap of prefixes then an opcode is a normal result
        for (int i = 0; i < 14; i++) seq[i] = 8'h3E;
        seq[14] = 8'hC3;
        e = '{4'd15, 48'h0, 8'hC3, 3'd4, 1'b0, 1'b0, 1'b0, 2'd0, 4'd14, 14'h1FFF};
        run_seq(15, 1'b0, e, 1'b0);

        // R9: one prefix beyond the cap ends the instruction with an error
        for (int i = 0; i < 15; i++) seq[i] = 8'h2E;
        e = '{4'd15, 48'h0, 8'h2E, 3'd2, 1'b0, 1'b0, 1'b0, 2'd0, 4'd14, 14'h1FFF};
        run_seq(15, 1'b0, e, 1'b1);

        // R8 R9: the next byte starts fresh with no error
        seq[0] = 8'h90;
        e = '{4'd1, 48'h0, 8'h90, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0, 14'h0};
        run_seq(1, 1'b0, e, 1'b0);

        finish_run();
    end
endmodule